// File: doc/BRIEF.md
# Three-channel match timer with captured count readout

This peripheral holds three 32-bit up-counters behind a simple word-addressed register bus. Each counter has three compare registers and a reload value. A small selector per counter names the comparator whose match makes the counter restart from its reload value. A single run register starts and stops the counters, one bit per counter. Every comparator match is recorded in a sticky status bit. Per-comparator enables turn the recorded events into one interrupt line per counter.

A running counter is never read straight off the bus. Software first writes a request, with a counter index, to the snapshot register. The block copies that counter at the moment the request is accepted. It keeps the copy in a staging register for a fixed number of cycles and then publishes it in the snapshot register, where software reads it. A busy flag shows that a request is still in flight. Requests made while busy are dropped.

Top module: `match_timer_snap`

## Requirements
- R1: After reset the following hold: every compare register holds all ones; reload values, reload selectors, run bits, status bits, interrupt enables and the snapshot register are all zero; busy and all interrupt lines are low.
- R2: The compare register for comparator c of counter t sits at word address 3*t + c (0 to 8), and each one reads back the value last written.
- R3: Run register (word 24), bit t: while set, counter t advances by one on every clock; while clear, the counter holds its value.
- R4: Reload selectors are at words 12 + t, in bits [1:0]. Value 0 means no reload, and value k (1 to 3) picks comparator k-1. When a running counter equals the picked compare value, its next value is the reload value of that counter (words 9 + t).
- R5: Without a reload, a counter at all ones steps to zero on its next count.
- R6: A write to a reload value changes neither the current count nor the counting; the new value is used only at the next reload match.
- R7: Status word 15 + t, bit c, is set on the clock after counter t, while running, equals compare value c. It stays set until a 1 is written to bit c of the clear word 21 + t. A set and a clear in the same cycle leave the bit set.
- R8: Interrupt line t is high exactly when some status bit c of counter t and enable bit c of word 18 + t are both 1.
- R9: Writing word 25 with bit 0 set and a counter index in bits [5:4] takes a copy of that counter's value at the write cycle. Busy (word 26, bit 0) then reads 1 for exactly 4 cycles. After that, word 25 reads the copy.
- R10: A snapshot request written while busy is 1 is ignored: it neither lengthens the busy window nor changes the value that is published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Interrupt line per counter |

## Verification
The case hardest to reach from the ports is a counter passing from all ones to zero. From reset, that would take about four billion cycles. The stimulus gets there by picking a small compare value as the reload trigger with a reload value just below all ones. The first match throws the counter close to the top of its range. The reload value is then rewritten while the counter runs. Snapshots taken before the wrap, just after it and after the next reload match show, in one sequence, the unaffected count, the wrap to zero and the new reload value taking effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR   = 3;
  localparam int NUM_CMP   = 3;
  localparam int ADDR_W    = 5;
  // word address map
  localparam int A_MATCH   = 0;
  localparam int A_PRELOAD = A_MATCH + NUM_TMR * NUM_CMP;
  localparam int A_PCTRL   = A_PRELOAD + NUM_TMR;
  localparam int A_STATUS  = A_PCTRL + NUM_TMR;
  localparam int A_IE      = A_STATUS + NUM_TMR;
  localparam int A_ICLR    = A_IE + NUM_TMR;
  localparam int A_RUN     = A_ICLR + NUM_TMR;
  localparam int A_SNAP    = A_RUN + 1;
  localparam int A_BUSY    = A_SNAP + 1;
  // snapshot request field: bit 0 request, counter index from this bit up
  localparam int SNAP_SEL_LSB = 4;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run_i,
  input  logic [CNT_W-1:0]               wdata_i,
  input  logic [NUM_CMP-1:0]             match_we_i,
  input  logic                           preload_we_i,
  input  logic                           pctrl_we_i,
  input  logic                           ie_we_i,
  input  logic                           iclr_we_i,
  output logic [CNT_W-1:0]               count_o,
  output logic [NUM_CMP-1:0][CNT_W-1:0]  match_o,
  output logic [CNT_W-1:0]               preload_o,
  output logic [SEL_W-1:0]               pctrl_o,
  output logic [NUM_CMP-1:0]             status_o,
  output logic [NUM_CMP-1:0]             ie_o,
  output logic                           irq_o
);
  logic [CNT_W-1:0]              count_q, count_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] match_q, match_d;
  logic [CNT_W-1:0]              preload_q, preload_d;
  logic [SEL_W-1:0]              pctrl_q, pctrl_d;
  logic [NUM_CMP-1:0]            status_q, status_d;
  logic [NUM_CMP-1:0]            ie_q, ie_d;
  logic [NUM_CMP-1:0]            hit;
  logic                          reload;
  logic [NUM_CMP-1:0]            clr_mask;

  // comparator events, only while the counter advances
  always_comb begin
    for (int c = 0; c < NUM_CMP; c++) begin
      hit[c] = run_i && (count_q == match_q[c]);
    end
  end

  // reload trigger chosen by the selector (0 = none)
  always_comb begin
    reload = 1'b0;
    for (int c = 0; c < NUM_CMP; c++) begin
      if ((pctrl_q == SEL_W'(c + 1)) && hit[c]) reload = 1'b1;
    end
  end

  always_comb begin
    match_d = match_q;
    for (int c = 0; c < NUM_CMP; c++) begin
      if (match_we_i[c]) match_d[c] = wdata_i;
    end
    preload_d = preload_we_i ? wdata_i : preload_q;
    pctrl_d   = pctrl_we_i ? wdata_i[SEL_W-1:0] : pctrl_q;
    ie_d      = ie_we_i ? wdata_i[NUM_CMP-1:0] : ie_q;
    clr_mask  = iclr_we_i ? wdata_i[NUM_CMP-1:0] : '0;
    status_d  = (status_q & ~clr_mask) | hit;
    if (!run_i)      count_d = count_q;
    else if (reload) count_d = preload_q;
    else             count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      match_q   <= '1;
      preload_q <= '0;
      pctrl_q   <= '0;
      status_q  <= '0;
      ie_q      <= '0;
    end else begin
      count_q   <= count_d;
      match_q   <= match_d;
      preload_q <= preload_d;
      pctrl_q   <= pctrl_d;
      status_q  <= status_d;
      ie_q      <= ie_d;
    end
  end

  assign count_o   = count_q;
  assign match_o   = match_q;
  assign preload_o = preload_q;
  assign pctrl_o   = pctrl_q;
  assign status_o  = status_q;
  assign ie_o      = ie_q;
  assign irq_o     = |(status_q & ie_q);

  // R3: a stopped counter keeps its value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> count_q == $past(count_q));

  // R4: a reload match loads the reload value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && reload) |=> count_q == $past(preload_q));

  // R6: rewriting the reload value leaves the count on its path
  p_preload_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !reload && preload_we_i) |=> count_q == $past(count_q) + 1'b1);

  // R8: an interrupt only rises after an event or an enable write
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(|hit) || $past(ie_we_i)));

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_chk
    // R7: every match event is recorded, even with a clear in the same cycle
    p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> status_q[c]);
  end
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int CNT_W   = 32,
  parameter int NUM_TMR = 3,
  parameter int LAT     = 4,
  parameter int TSEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_i,
  input  logic [TSEL_W-1:0]             sel_i,
  input  logic [NUM_TMR-1:0][CNT_W-1:0] counts_i,
  output logic                          busy_o,
  output logic [CNT_W-1:0]              snap_o
);
  localparam int LAT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [CNT_W-1:0] picked;
  logic             accept;

  always_comb begin
    picked = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (sel_i == TSEL_W'(t)) picked = counts_i[t];
    end
  end

  assign busy_o = (lat_q != '0);
  assign accept = req_i && !busy_o;

  always_comb begin
    stage_d = accept ? picked : stage_q;
    if (accept)        lat_d = LAT_W'(LAT);
    else if (busy_o)   lat_d = lat_q - 1'b1;
    else               lat_d = lat_q;
    snap_d = (lat_q == LAT_W'(1)) ? stage_q : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      snap_q  <= '0;
      lat_q   <= '0;
    end else begin
      stage_q <= stage_d;
      snap_q  <= snap_d;
      lat_q   <= lat_d;
    end
  end

  assign snap_o = snap_q;

  // checker: length of each busy window
  logic [31:0] chk_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_len_q <= '0;
    else if (busy_o) chk_len_q <= chk_len_q + 1;
    else             chk_len_q <= '0;
  end

  // R9: busy lasts exactly LAT cycles
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> chk_len_q == 32'(LAT));

  // R9: the published value is the staged copy
  p_publish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> snap_o == $past(stage_q));

  // R10: a request while busy leaves the staged copy alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(stage_q));

  // R9: an accepted request raises busy
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/match_timer_snap.sv
module match_timer_snap
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int CAP_LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic [NUM_TMR-1:0]   irq
);
  localparam int SEL_W  = $clog2(NUM_CMP + 1);
  localparam int TSEL_W = $clog2(NUM_TMR);

  logic                                      srst_n;
  logic [NUM_TMR-1:0]                        run_q, run_d;
  logic [NUM_TMR-1:0][CNT_W-1:0]             cnt_w, pre_w;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] mat_w;
  logic [NUM_TMR-1:0][SEL_W-1:0]             pc_w;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]           st_w, ie_w;
  logic                                      snap_req, snap_busy;
  logic [TSEL_W-1:0]                         snap_sel;
  logic [CNT_W-1:0]                          snap_val;
  logic                                      run_we;

  tmr_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic [NUM_CMP-1:0] m_we;
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_mwe
      assign m_we[c] = bus_wr && (bus_addr == ADDR_W'(A_MATCH + t * NUM_CMP + c));
    end

    tmr_channel #(
      .CNT_W   (CNT_W),
      .NUM_CMP (NUM_CMP),
      .SEL_W   (SEL_W)
    ) i_chan (
      .clk          (clk),
      .rst_n        (srst_n),
      .run_i        (run_q[t]),
      .wdata_i      (bus_wdata),
      .match_we_i   (m_we),
      .preload_we_i (bus_wr && (bus_addr == ADDR_W'(A_PRELOAD + t))),
      .pctrl_we_i   (bus_wr && (bus_addr == ADDR_W'(A_PCTRL + t))),
      .ie_we_i      (bus_wr && (bus_addr == ADDR_W'(A_IE + t))),
      .iclr_we_i    (bus_wr && (bus_addr == ADDR_W'(A_ICLR + t))),
      .count_o      (cnt_w[t]),
      .match_o      (mat_w[t]),
      .preload_o    (pre_w[t]),
      .pctrl_o      (pc_w[t]),
      .status_o     (st_w[t]),
      .ie_o         (ie_w[t]),
      .irq_o        (irq[t])
    );
  end

  assign run_we   = bus_wr && (bus_addr == ADDR_W'(A_RUN));
  assign snap_req = bus_wr && (bus_addr == ADDR_W'(A_SNAP)) && bus_wdata[0];
  assign snap_sel = bus_wdata[SNAP_SEL_LSB +: TSEL_W];

  always_comb run_d = run_we ? bus_wdata[NUM_TMR-1:0] : run_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) run_q <= '0;
    else         run_q <= run_d;
  end

  tmr_snap #(
    .CNT_W   (CNT_W),
    .NUM_TMR (NUM_TMR),
    .LAT     (CAP_LAT),
    .TSEL_W  (TSEL_W)
  ) i_snap (
    .clk      (clk),
    .rst_n    (srst_n),
    .req_i    (snap_req),
    .sel_i    (snap_sel),
    .counts_i (cnt_w),
    .busy_o   (snap_busy),
    .snap_o   (snap_val)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      for (int c = 0; c < NUM_CMP; c++) begin
        if (bus_addr == ADDR_W'(A_MATCH + t * NUM_CMP + c)) bus_rdata = mat_w[t][c];
      end
      if (bus_addr == ADDR_W'(A_PRELOAD + t)) bus_rdata = pre_w[t];
      if (bus_addr == ADDR_W'(A_PCTRL + t))   bus_rdata = CNT_W'(pc_w[t]);
      if (bus_addr == ADDR_W'(A_STATUS + t))  bus_rdata = CNT_W'(st_w[t]);
      if (bus_addr == ADDR_W'(A_IE + t))      bus_rdata = CNT_W'(ie_w[t]);
    end
    if (bus_addr == ADDR_W'(A_RUN))  bus_rdata = CNT_W'(run_q);
    if (bus_addr == ADDR_W'(A_SNAP)) bus_rdata = snap_val;
    if (bus_addr == ADDR_W'(A_BUSY)) bus_rdata = CNT_W'(snap_busy);
  end

  // R3: run register takes the written bits
  p_run_write_r3: assert property (@(posedge clk) disable iff (!srst_n)
    run_we |=> run_q == $past(bus_wdata[NUM_TMR-1:0]));

  // R1: interrupts stay low while in reset
  p_irq_reset_r1: assert property (@(posedge clk)
    !srst_n |-> irq == '0);
endmodule

// File: tb/test_match_timer_snap.sv
`timescale 1ns/1ps
module test_match_timer_snap;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  match_timer_snap i_match_timer_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(addr); bus_wdata = data;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 5'(addr);
    #1 chk(tag, bus_rdata, exp);
  endtask

  // request a snapshot and check the busy window and result (R9)
  task automatic cap(input int sel, input logic [31:0] exp, input string tag);
    wr(A_SNAP, 32'((sel << SNAP_SEL_LSB) | 1));
    repeat (3) @(posedge clk);
    #1 bus_addr = 5'(A_BUSY);
    #1 chk({tag, " R9 busy high"}, bus_rdata, 32'd1);
    @(posedge clk);
    #1 bus_addr = 5'(A_BUSY);
    #1 chk({tag, " R9 busy low"}, bus_rdata, 32'd0);
    bus_addr = 5'(A_SNAP);
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk(0, 32'hFFFF_FFFF, "R1 match0 reset");
    rd_chk(8, 32'hFFFF_FFFF, "R1 match8 reset");
    rd_chk(A_PRELOAD, 32'd0, "R1 reload reset");
    rd_chk(A_PCTRL + 2, 32'd0, "R1 selector reset");
    rd_chk(A_STATUS + 1, 32'd0, "R1 status reset");
    rd_chk(A_RUN, 32'd0, "R1 run reset");
    rd_chk(A_BUSY, 32'd0, "R1 busy reset");
    rd_chk(A_SNAP, 32'd0, "R1 snapshot reset");
    chk("R1 irq reset", 32'(irq), 32'd0);
    repeat (5) @(posedge clk);
    cap(1, 32'd0, "R1 R3 stopped count stays 0");
  endtask

  task automatic t_match_map;
    for (int i = 0; i < 9; i++) wr(i, 32'hA000_0000 + 32'(i * 16 + 5));
    for (int i = 0; i < 9; i++) rd_chk(i, 32'hA000_0000 + 32'(i * 16 + 5), "R2 compare readback");
  endtask

  // counter 2: comparator 2 = 3, reload 100, selector 3
  task automatic t_reload_sel3;
    wr(2 * 3 + 2, 32'd3);
    wr(A_PRELOAD + 2, 32'd100);
    wr(A_PCTRL + 2, 32'd3);
    wr(A_IE + 2, 32'd4);
    wr(A_RUN, 32'd4);
    repeat (20) @(posedge clk);
    cap(2, 32'd116, "R4 reload via comparator 2");
    rd_chk(A_STATUS + 2, 32'd4, "R7 status comparator 2");
    chk("R8 irq2 with enable", 32'(irq[2]), 32'd1);
  endtask

  // counter 1: comparator 0 = 4, reload 10, selector 1, enables off
  task automatic t_irq_sel1;
    wr(1 * 3 + 0, 32'd4);
    wr(A_PRELOAD + 1, 32'd10);
    wr(A_PCTRL + 1, 32'd1);
    wr(A_RUN, 32'd2);
    repeat (10) @(posedge clk);
    wr(A_RUN, 32'd0);
    rd_chk(A_STATUS + 1, 32'd1, "R7 status comparator 0");
    chk("R8 irq1 masked", 32'(irq[1]), 32'd0);
    cap(1, 32'd16, "R4 reload via comparator 0");
    repeat (7) @(posedge clk);
    cap(1, 32'd16, "R3 stopped counter holds");
    wr(A_IE + 1, 32'd1);
    chk("R8 irq1 enabled", 32'(irq[1]), 32'd1);
    wr(A_ICLR + 1, 32'd1);
    chk("R7 R8 irq1 after clear", 32'(irq[1]), 32'd0);
    rd_chk(A_STATUS + 1, 32'd0, "R7 status cleared");
  endtask

  // counter 0: wrap and reload-value change while running
  task automatic t_wrap;
    wr(0 * 3 + 1, 32'd2);
    wr(A_PRELOAD, 32'hFFFF_FFF0);
    wr(A_PCTRL, 32'd2);
    wr(A_RUN, 32'd1);
    repeat (5) @(posedge clk);
    wr(A_PRELOAD, 32'h55);
    repeat (2) @(posedge clk);
    cap(0, 32'hFFFF_FFF5, "R6 count unaffected by reload write");
    repeat (6) @(posedge clk);
    cap(0, 32'd0, "R5 wrap from all ones");
    cap(0, 32'h57, "R6 new reload value used at next match");
    wr(A_RUN, 32'd0);
    rd_chk(A_STATUS, 32'd2, "R7 status comparator 1");
  endtask

  // request while busy is dropped
  task automatic t_busy_ignore;
    cap(0, 32'h5D, "R3 counter 0 stopped value");
    wr(A_SNAP, 32'h01);
    wr(A_SNAP, 32'h11);
    repeat (2) @(posedge clk);
    #1 bus_addr = 5'(A_BUSY);
    #1 chk("R10 busy still high", bus_rdata, 32'd1);
    @(posedge clk);
    #1 bus_addr = 5'(A_BUSY);
    #1 chk("R10 busy not extended", bus_rdata, 32'd0);
    bus_addr = 5'(A_SNAP);
    #1 chk("R10 second request ignored", bus_rdata, 32'h5D);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_match_map();
    t_reload_sel3();
    t_irq_sel1();
    t_wrap();
    t_busy_ignore();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule